// File: doc/BRIEF.md
# Dual Auto-Stepping Memory Access Port

This block lets a byte-wide host processor fill and inspect a large banked local memory through a small register window. The memory holds eight banks, each addressed by 16 bits. The host sees two independent access channels. Each channel has a 16-bit pointer, split into a low byte and a high byte, an 8-bit stride and a data register. Storing a byte into a channel's data register writes that byte to memory at the pointer. The pointer then moves forward by the stride. This lets software stream a table into memory without reloading the address for every byte.

Reads through a data register also return the memory byte and move the pointer. They do this only while a read-enable bit in the shared control register is set. Some processors issue a dummy bus read of a location just before they write it. With read-enable clear, such a read returns 0xFF, issues no memory request and leaves the pointer where it was. A shared bank register supplies the upper memory address bits for both channels.

The memory behind the block is synchronous with one cycle of read latency. The block drives the request, write-enable, address and write data combinationally in the cycle of the host access, and the memory samples them on the following edge. Every host read, whether of a register or of memory, returns its data together with a one-cycle valid pulse in the cycle after the read strobe.

Top module: `dual_step_port`

## Requirements
- R1: After reset the control byte, the bank and both channels' pointers and strides read as 0x00. While neither host strobe is high, memReq stays low.
- R2: Writing offset 4 (channel 0) or 8 (channel 1) replaces only the pointer's low byte. Writing offset 5 or 9 replaces only the high byte. Neither write moves the pointer, and both bytes read back at the same offsets.
- R3: Writing offset 7 (channel 0) or 11 (channel 1) raises memReq and memWe for that cycle. It drives memAddr = {bank, pointer} and memWdata = the host byte. On the next edge the pointer becomes pointer + stride. The stride registers are at offsets 6 and 10.
- R4: The pointer advance wraps modulo 2^16 and does not touch the bank. The stride is an unsigned 8-bit value, so 0xFF adds 255.
- R5: When control bit 0 (offset 0) is 1, reading offset 7 or 11 issues a memory read at {bank, pointer}. It returns that byte on hostRdata in the next cycle and advances the pointer by the stride.
- R6: When control bit 0 is 0, reading offset 7 or 11 returns 0xFF, raises no memReq and leaves the pointer unchanged.
- R7: A transfer on one channel never changes the other channel's pointer or stride.
- R8: Bits 2:0 of the bank register (offset 1) form memAddr[18:16] for every memory access of both channels.
- R9: A host read with hostWr low produces hostRdValid high for exactly the next cycle, with the data on hostRdata. Offsets 2, 3 and 12 to 15 read as 0x00.
- R10: With a stride of 0, repeated transfers hit the same address and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWr | input | 1 | Host register write strobe (wins over hostRd) |
| hostRd | input | 1 | Host register read strobe |
| regAddr | input | 4 | Register offset |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Read data, valid with hostRdValid |
| hostRdValid | output | 1 | One-cycle pulse in the cycle after a host read |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 19 | Memory address {bank, pointer} |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte, one cycle after the request |

## Verification
The bench targets four kinds of fault. Pointer wrap at 0xFFFF with a large stride would show up as a carry leaking into the bank field, or as a signed stride moving the pointer backwards. A read of the data register while read-enable is clear must not touch memory or the pointer; a design that gated only the returned data would still skip a byte on the next real read. The bench also looks for writes to one pointer byte that clobber the other, and for one channel's transfer that advances the wrong channel. A zero stride and bank switching under a fixed pointer are both checked through the memory contents read back.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int NumPorts = 2;

  typedef struct packed {
    logic                wrCtrl;
    logic                wrBank;
    logic [NumPorts-1:0] wrLo;
    logic [NumPorts-1:0] wrHi;
    logic [NumPorts-1:0] wrStep;
    logic [NumPorts-1:0] wrData;
    logic [NumPorts-1:0] rdData;
    logic                rdBlocked;
    logic                rdReg;
  } strobe_t;
endpackage

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              readEn,
  output strobe_t           stb
);
  localparam int GrpW = REG_AW - 2;

  logic [GrpW-1:0] grp;
  logic [1:0]      fld;
  assign grp = regAddr[REG_AW-1:2];
  assign fld = regAddr[1:0];

  always_comb begin
    stb = '0;
    if (hostWr) begin
      stb.wrCtrl = (regAddr == REG_AW'(0));
      stb.wrBank = (regAddr == REG_AW'(1));
      for (int p = 0; p < NumPorts; p++) begin
        if (int'(grp) == p + 1) begin
          stb.wrLo[p]   = (fld == 2'd0);
          stb.wrHi[p]   = (fld == 2'd1);
          stb.wrStep[p] = (fld == 2'd2);
          stb.wrData[p] = (fld == 2'd3);
        end
      end
    end else if (hostRd) begin
      stb.rdReg = 1'b1;
      for (int p = 0; p < NumPorts; p++) begin
        if (int'(grp) == p + 1 && fld == 2'd3) begin
          stb.rdReg = 1'b0;
          if (readEn) stb.rdData[p] = 1'b1;
          else        stb.rdBlocked = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsp_datapath.sv
module dsp_datapath
  import dsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  parameter int REG_AW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    stb,
  input  logic [REG_AW-1:0]          regAddr,
  input  logic [DATA_W-1:0]          hostWdata,
  output logic [DATA_W-1:0]          hostRdata,
  output logic                       hostRdValid,
  output logic                       readEn,
  output logic [BANK_W-1:0]          bankReg,
  output logic                       memReq,
  output logic                       memWe,
  output logic [BANK_W+2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]          memWdata,
  input  logic [DATA_W-1:0]          memRdata
);
  localparam int PtrW = 2 * DATA_W;

  logic [PtrW-1:0]   ptrQ  [NumPorts];
  logic [DATA_W-1:0] stepQ [NumPorts];
  logic [DATA_W-1:0] regVal;
  logic [DATA_W-1:0] rdHold;
  logic              rdFromMem;

  always_ff @(posedge clk) begin
    if (rst) begin
      readEn  <= 1'b0;
      bankReg <= '0;
      for (int p = 0; p < NumPorts; p++) begin
        ptrQ[p]  <= '0;
        stepQ[p] <= '0;
      end
    end else begin
      if (stb.wrCtrl) readEn  <= hostWdata[0];
      if (stb.wrBank) bankReg <= hostWdata[BANK_W-1:0];
      for (int p = 0; p < NumPorts; p++) begin
        if (stb.wrLo[p])   ptrQ[p][DATA_W-1:0]    <= hostWdata;
        if (stb.wrHi[p])   ptrQ[p][PtrW-1:DATA_W] <= hostWdata;
        if (stb.wrStep[p]) stepQ[p]               <= hostWdata;
        if (stb.wrData[p] || stb.rdData[p])
          ptrQ[p] <= ptrQ[p] + PtrW'(stepQ[p]);
      end
    end
  end

  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memWdata = hostWdata;
    for (int p = 0; p < NumPorts; p++) begin
      if (stb.wrData[p] || stb.rdData[p]) begin
        memReq  = 1'b1;
        memWe   = stb.wrData[p];
        memAddr = {bankReg, ptrQ[p]};
      end
    end
  end

  always_comb begin
    regVal = '0;
    if (regAddr == REG_AW'(0)) regVal = DATA_W'(readEn);
    if (regAddr == REG_AW'(1)) regVal = DATA_W'(bankReg);
    for (int p = 0; p < NumPorts; p++) begin
      if (int'(regAddr[REG_AW-1:2]) == p + 1) begin
        case (regAddr[1:0])
          2'd0:    regVal = ptrQ[p][DATA_W-1:0];
          2'd1:    regVal = ptrQ[p][PtrW-1:DATA_W];
          2'd2:    regVal = stepQ[p];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hostRdValid <= 1'b0;
      rdFromMem   <= 1'b0;
      rdHold      <= '0;
    end else begin
      hostRdValid <= stb.rdReg || stb.rdBlocked || (|stb.rdData);
      rdFromMem   <= |stb.rdData;
      rdHold      <= stb.rdBlocked ? {DATA_W{1'b1}} : regVal;
    end
  end

  assign hostRdata = rdFromMem ? memRdata : rdHold;
endmodule

// File: rtl/dual_step_port.sv
module dual_step_port
  import dsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  parameter int REG_AW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hostWr,
  input  logic                       hostRd,
  input  logic [REG_AW-1:0]          regAddr,
  input  logic [DATA_W-1:0]          hostWdata,
  output logic [DATA_W-1:0]          hostRdata,
  output logic                       hostRdValid,
  output logic                       memReq,
  output logic                       memWe,
  output logic [BANK_W+2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]          memWdata,
  input  logic [DATA_W-1:0]          memRdata
);
  strobe_t           stb;
  logic              readEn;
  logic [BANK_W-1:0] bankReg;

  dsp_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .hostWr  (hostWr),
    .hostRd  (hostRd),
    .regAddr (regAddr),
    .readEn  (readEn),
    .stb     (stb)
  );

  dsp_datapath #(.DATA_W(DATA_W), .BANK_W(BANK_W), .REG_AW(REG_AW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .regAddr     (regAddr),
    .hostWdata   (hostWdata),
    .hostRdata   (hostRdata),
    .hostRdValid (hostRdValid),
    .readEn      (readEn),
    .bankReg     (bankReg),
    .memReq      (memReq),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memRdata    (memRdata)
  );
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker
  import dsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  parameter int REG_AW = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       hostWr,
  input logic                       hostRd,
  input logic [REG_AW-1:0]          regAddr,
  input logic [DATA_W-1:0]          hostRdata,
  input logic                       hostRdValid,
  input logic                       memReq,
  input logic                       memWe,
  input logic [BANK_W+2*DATA_W-1:0] memAddr,
  input logic                       readEn,
  input logic [BANK_W-1:0]          bankReg
);
  localparam int MemAW = BANK_W + 2 * DATA_W;

  logic dataOff;
  always_comb begin
    dataOff = 1'b0;
    for (int p = 0; p < NumPorts; p++)
      if (int'(regAddr[REG_AW-1:2]) == p + 1 && regAddr[1:0] == 2'd3) dataOff = 1'b1;
  end

  assert_idle_noreq_R1: assert property (@(posedge clk) disable iff (rst)
    !(hostWr || hostRd) |-> !memReq);

  assert_write_needs_host_R3: assert property (@(posedge clk) disable iff (rst)
    (memReq && memWe) |-> hostWr);

  assert_blocked_noreq_R6: assert property (@(posedge clk) disable iff (rst)
    (hostRd && !hostWr && dataOff && !readEn) |-> !memReq);

  assert_blocked_ff_R6: assert property (@(posedge clk) disable iff (rst)
    (hostRd && !hostWr && dataOff && !readEn) |=> (hostRdata == {DATA_W{1'b1}}));

  assert_bank_bits_R8: assert property (@(posedge clk) disable iff (rst)
    memReq |-> (memAddr[MemAW-1 -: BANK_W] == bankReg));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (hostRd && !hostWr) |=> hostRdValid);

  assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !hostRd |=> !hostRdValid);
endmodule

bind dual_step_port dsp_checker #(.DATA_W(DATA_W), .BANK_W(BANK_W), .REG_AW(REG_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hostWr      (hostWr),
  .hostRd      (hostRd),
  .regAddr     (regAddr),
  .hostRdata   (hostRdata),
  .hostRdValid (hostRdValid),
  .memReq      (memReq),
  .memWe       (memWe),
  .memAddr     (memAddr),
  .readEn      (u_dp.readEn),
  .bankReg     (u_dp.bankReg)
);

// File: tb/sim_dual_step_port.sv
`timescale 1ns/1ps
module sim_dual_step_port;
  localparam int MemAW = 19;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hostWr = 1'b0, hostRd = 1'b0;
  logic [3:0]       regAddr = '0;
  logic [7:0]       hostWdata = '0;
  logic [7:0]       hostRdata;
  logic             hostRdValid;
  logic             memReq, memWe;
  logic [MemAW-1:0] memAddr;
  logic [7:0]       memWdata;
  logic [7:0]       memRdata = '0;

  int testCount = 0;
  int failCount = 0;

  dual_step_port u0 (.*);

  always #2.5 clk = ~clk;

  // Synchronous memory behind the block
  logic [7:0] ram [logic [MemAW-1:0]];
  always @(posedge clk) begin
    if (memReq && memWe) ram[memAddr] = memWdata;
    if (memReq && !memWe) memRdata <= ram.exists(memAddr) ? ram[memAddr] : 8'h00;
  end

  // Behavioural reference model
  int mRen, mBank;
  int mPtr  [2];
  int mStep [2];
  int mRam  [int];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dataPort(input int a);
    if (a == 7) return 0;
    if (a == 11) return 1;
    return -1;
  endfunction

  function automatic int regModel(input int a);
    int p;
    if (a == 0) return mRen;
    if (a == 1) return mBank;
    if (a >= 4 && a <= 11) begin
      p = a / 4 - 1;
      case (a % 4)
        0: return mPtr[p] & 255;
        1: return (mPtr[p] >> 8) & 255;
        2: return mStep[p];
        default: return 255;
      endcase
    end
    return 0;
  endfunction

  task automatic access(input bit wr, input int a, input int d, input string req);
    int p, key, expRd;
    bit expReq;
    p = dataPort(a);
    expReq = (p >= 0) && (wr || mRen == 1);
    key = (p >= 0) ? ((mBank << 16) | mPtr[p]) : 0;
    if (!wr) begin
      if (p >= 0 && mRen == 1) expRd = mRam.exists(key) ? mRam[key] : 0;
      else expRd = regModel(a);
    end
    @(negedge clk);
    hostWr = wr; hostRd = !wr; regAddr = 4'(a); hostWdata = 8'(d);
    #1;
    chk(memReq == expReq, req, int'(memReq), int'(expReq));
    if (expReq) begin
      chk(int'(memAddr) == key, req, int'(memAddr), key);
      chk(memWe == wr, req, int'(memWe), int'(wr));
    end
    @(posedge clk);
    if (wr) begin
      if (a == 0) mRen = d & 1;
      else if (a == 1) mBank = d & 7;
      else if (a >= 4 && a <= 11) begin
        case (a % 4)
          0: mPtr[a/4-1] = (mPtr[a/4-1] & 16'hFF00) | (d & 255);
          1: mPtr[a/4-1] = (mPtr[a/4-1] & 16'h00FF) | ((d & 255) << 8);
          2: mStep[a/4-1] = d & 255;
          default: begin
            mRam[key] = d & 255;
            mPtr[p] = (mPtr[p] + mStep[p]) % 65536;
          end
        endcase
      end
    end else if (expReq) begin
      mPtr[p] = (mPtr[p] + mStep[p]) % 65536;
    end
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    if (!wr) begin
      chk(hostRdValid == 1'b1, req, int'(hostRdValid), 1);
      chk(int'(hostRdata) == expRd, req, int'(hostRdata), expRd);
    end
  endtask

  task automatic wr(input int a, input int d, input string req);
    access(1'b1, a, d, req);
  endtask

  task automatic rd(input int a, input string req);
    access(1'b0, a, 0, req);
  endtask

  task automatic setPtr(input int port, input int v, input string req);
    wr(4 + 4*port, v & 255, req);
    wr(5 + 4*port, (v >> 8) & 255, req);
  endtask

  initial begin
    mRen = 0; mBank = 0;
    for (int i = 0; i < 2; i++) begin mPtr[i] = 0; mStep[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    chk(memReq == 1'b0 && hostRdValid == 1'b0, "R1", int'(memReq), 0);
    for (int a = 0; a < 16; a++) if (a != 7 && a != 11) rd(a, "R1");
    // R9: unmapped offsets and valid pulse width
    wr(2, 8'h5A, "R9"); rd(2, "R9"); rd(13, "R9");
    @(negedge clk); chk(hostRdValid == 1'b0, "R9", int'(hostRdValid), 0);
    // R2: separate pointer bytes, no advance
    wr(6, 1, "R2");
    setPtr(0, 16'h1234, "R2");
    rd(4, "R2"); rd(5, "R2");
    wr(5, 8'h77, "R2"); rd(4, "R2"); rd(5, "R2");
    setPtr(0, 16'h1234, "R2");
    // R3: data writes with stride 1
    wr(7, 8'hA1, "R3"); wr(7, 8'hA2, "R3"); wr(7, 8'hA3, "R3");
    rd(4, "R3"); rd(5, "R3");
    // R6: blocked reads
    rd(7, "R6"); rd(7, "R6"); rd(4, "R6");
    // R5: enabled reads
    wr(0, 1, "R5"); rd(0, "R5");
    setPtr(0, 16'h1234, "R5");
    rd(7, "R5"); rd(7, "R5"); rd(7, "R5"); rd(4, "R5");
    // R4 and R8: wrap with bank 5, stride 3 then 0xFF
    wr(1, 5, "R8"); rd(1, "R8");
    wr(10, 3, "R4"); setPtr(1, 16'hFFFE, "R4");
    wr(11, 8'h5C, "R4"); rd(8, "R4"); rd(9, "R4"); rd(1, "R4");
    wr(10, 8'hFF, "R4"); wr(11, 8'h6D, "R4"); rd(8, "R4"); rd(9, "R4");
    // R7: channel 0 untouched by channel 1
    rd(4, "R7"); rd(5, "R7"); rd(6, "R7");
    wr(7, 8'h11, "R7"); rd(8, "R7"); rd(9, "R7"); rd(10, "R7");
    // R10: zero stride
    wr(6, 0, "R10"); setPtr(0, 16'h0400, "R10");
    wr(7, 8'h21, "R10"); wr(7, 8'h22, "R10"); rd(4, "R10"); rd(5, "R10");
    rd(7, "R10"); rd(7, "R10");
    // R8: same pointer, different banks
    wr(1, 2, "R8"); wr(7, 8'h33, "R8");
    wr(1, 6, "R8"); wr(7, 8'h44, "R8");
    wr(1, 2, "R8"); rd(7, "R8");
    wr(1, 6, "R8"); rd(7, "R8");
    // R6 again after disabling, channel 1
    wr(0, 0, "R6"); rd(11, "R6"); rd(8, "R6"); rd(9, "R6");
    // R5 on channel 1 reading back the wrapped write
    wr(0, 1, "R5"); wr(1, 5, "R5"); wr(10, 3, "R5");
    setPtr(1, 16'hFFFE, "R5"); rd(11, "R5"); rd(8, "R5");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    failCount++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule